// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block models the part of a processor core that takes and leaves interrupts. The core pulses an instruction-boundary strobe each time an instruction completes. At that edge, and only then, the sequencer looks at several inputs: a software-interrupt command with its 8-bit vector, a return command, a nonmaskable request and a maskable request with its own vector. It picks one event. For an entry it saves the flags word, the code segment and the return instruction pointer on a descending stack through a simple synchronous memory port. It then reads the handler's code pointer from the vector table and loads it. A return command reads the three saved words back and restores them.

The block owns the flags word, code segment, instruction pointer and stack pointer, and shows all four on its outputs. The enable/disable-interrupt commands of the finishing instruction are applied at the same boundary. A clear takes effect immediately. A set only affects boundaries after the current one. The vector table uses 4-byte entries in real mode and 8-byte entries in protected mode. An optional error code can be pushed as a fourth word. While the sequencer is busy the core holds back its next boundary.

Top module: `irq_seq`

## Requirements
- R1: After reset, ip_o is FFF0h, cs_o is F000h, flags_o is 0002h, sp_o is 1000h, busy_o is low and no memory request is issued.
- R2: On an accepted entry, three words are written. Before each write the stack pointer drops by 2 bytes. The order is: the flags word (with that boundary's enable/disable command already applied), then cs_o, then next_ip_i. The stack pointer ends 6 lower.
- R3: When ec_vld_i is high at an accepted entry, ec_i is written as a fourth word below the return pointer, and the stack pointer ends 8 lower.
- R4: An entry clears the interrupt-enable flag (flags bit 9) and leaves every other flag bit as it was.
- R5: The table entry address is vector×4 with pmode_i low and vector×8 with pmode_i high. The new ip_o is the word read at that address and the new cs_o is the word at address+2.
- R6: A return command reads the instruction pointer, then the code segment, then the flags word from ascending addresses starting at sp_o, and raises the stack pointer by 6.
- R7: With cli_i high at a boundary, or flags bit 9 clear, a maskable request at that boundary is ignored, and the boundary clears bit 9.
- R8: With sti_i high at a boundary, bit 9 becomes set, but a maskable request at that same boundary is not taken when bit 9 was clear before it. The request is taken at the next boundary.
- R9: A nonmaskable request is taken whatever bit 9 holds, uses vector 2, and wins over a maskable request at the same boundary.
- R10: Requests and commands have no effect unless bnd_i is high while the sequencer is idle.
- R11: A software interrupt or return command at a boundary is acted on ahead of any hardware request present at the same boundary.
- R12: A boundary that takes no event loads next_ip_i into ip_o and leaves cs_o and sp_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bnd_i | input | 1 | Instruction-boundary strobe, one cycle |
| next_ip_i | input | DW | Address of the following instruction |
| swi_i | input | 1 | Finishing instruction is a software interrupt |
| swi_vec_i | input | 8 | Software interrupt vector |
| iret_i | input | 1 | Finishing instruction is an interrupt return |
| nmi_i | input | 1 | Nonmaskable request level |
| intr_i | input | 1 | Maskable request level |
| intr_vec_i | input | 8 | Vector of the maskable request |
| sti_i | input | 1 | Finishing instruction sets the enable flag |
| cli_i | input | 1 | Finishing instruction clears the enable flag |
| ec_vld_i | input | 1 | Push an error code with this entry |
| ec_i | input | DW | Error code value |
| pmode_i | input | 1 | High selects 8-byte table entries |
| busy_o | output | 1 | Sequence in progress; no boundary allowed |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Byte address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid the cycle after a read request |
| flags_o | output | DW | Flags word |
| cs_o | output | DW | Code segment |
| ip_o | output | DW | Instruction pointer |
| sp_o | output | AW | Stack pointer |

## Verification
The functions that collide are the enable/disable command of the finishing instruction and the sampling of the maskable request at the same boundary. The nonmaskable and software paths can also meet there. Stimulus rows raise the set-enable command together with a maskable request while the flag is clear, and the clear command together with a request while the flag is set. They also raise a nonmaskable request alongside a maskable one, and alongside a software interrupt. Each row is judged by the stack pointer, the stack words and the loaded code pointer. A reference model in the bench works these out from the requirements.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PFL,
        S_PCS,
        S_PIP,
        S_PEC,
        S_ROFF,
        S_RSEG,
        S_LSEG,
        S_OIP,
        S_OCS,
        S_OFL,
        S_LFL
    } st_e;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_ENTER,
        ACT_RET
    } act_e;

endpackage

// File: rtl/irq_seq_arb.sv
module irq_seq_arb
    import irq_seq_pkg::*;
#(
    parameter logic [7:0] NMI_VEC = 8'd2
) (
    input  logic       swi_i,
    input  logic       iret_i,
    input  logic       nmi_i,
    input  logic       intr_i,
    input  logic       mask_ok_i,
    input  logic [7:0] swi_vec_i,
    input  logic [7:0] intr_vec_i,
    output act_e       act_o,
    output logic [7:0] vec_o
);

    // Commands of the finishing instruction first, then NMI, then INTR.
    always_comb begin
        act_o = ACT_NONE;
        vec_o = 8'd0;
        if (swi_i) begin
            act_o = ACT_ENTER;
            vec_o = swi_vec_i;
        end else if (iret_i) begin
            act_o = ACT_RET;
        end else if (nmi_i) begin
            act_o = ACT_ENTER;
            vec_o = NMI_VEC;
        end else if (intr_i && mask_ok_i) begin
            act_o = ACT_ENTER;
            vec_o = intr_vec_i;
        end
    end

endmodule

// File: rtl/irq_seq_vaddr.sv
module irq_seq_vaddr #(
    parameter int AW = 16
) (
    input  logic [7:0]    vec_i,
    input  logic          pmode_i,
    output logic [AW-1:0] addr_o
);

    localparam int SH_REAL = 2;  // 4-byte entries
    localparam int SH_PROT = 3;  // 8-byte entries

    logic [AW-1:0] vec_w;
    assign vec_w  = AW'(vec_i);
    assign addr_o = pmode_i ? (vec_w << SH_PROT) : (vec_w << SH_REAL);

endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_seq_pkg::*;
#(
    parameter int            DW      = 16,
    parameter int            AW      = 16,
    parameter logic [15:0]   SP_RST  = 16'h1000,
    parameter logic [15:0]   CS_RST  = 16'hF000,
    parameter logic [15:0]   IP_RST  = 16'hFFF0,
    parameter logic [15:0]   FL_RST  = 16'h0002,
    parameter int            IF_BIT  = 9,
    parameter logic [7:0]    NMI_VEC = 8'd2
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          bnd_i,
    input  logic [DW-1:0] next_ip_i,
    input  logic          swi_i,
    input  logic [7:0]    swi_vec_i,
    input  logic          iret_i,
    input  logic          nmi_i,
    input  logic          intr_i,
    input  logic [7:0]    intr_vec_i,
    input  logic          sti_i,
    input  logic          cli_i,
    input  logic          ec_vld_i,
    input  logic [DW-1:0] ec_i,
    input  logic          pmode_i,
    output logic          busy_o,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic [DW-1:0] mem_rdata_i,
    output logic [DW-1:0] flags_o,
    output logic [DW-1:0] cs_o,
    output logic [DW-1:0] ip_o,
    output logic [AW-1:0] sp_o
);

    localparam int            WB    = DW / 8;
    localparam logic [AW-1:0] WSTEP = AW'(WB);

    typedef struct packed {
        st_e           st;
        logic [DW-1:0] fl;
        logic [DW-1:0] cs;
        logic [DW-1:0] ip;
        logic [AW-1:0] sp;
        logic [DW-1:0] sav_fl;
        logic [DW-1:0] sav_ip;
        logic [DW-1:0] ec;
        logic          ecv;
        logic [AW-1:0] tab;
    } seq_s;

    seq_s seq_d, seq_q;

    act_e          act;
    logic [7:0]    vec;
    logic [AW-1:0] tab_addr;
    logic          mask_ok;
    logic [DW-1:0] fl_upd;

    // CLI acts at its own boundary; STI only from the next one on.
    assign mask_ok = seq_q.fl[IF_BIT] && !cli_i;

    always_comb begin
        fl_upd = seq_q.fl;
        if (sti_i) fl_upd[IF_BIT] = 1'b1;
        if (cli_i) fl_upd[IF_BIT] = 1'b0;
    end

    irq_seq_arb #(.NMI_VEC(NMI_VEC)) u_arb (
        .swi_i      (swi_i),
        .iret_i     (iret_i),
        .nmi_i      (nmi_i),
        .intr_i     (intr_i),
        .mask_ok_i  (mask_ok),
        .swi_vec_i  (swi_vec_i),
        .intr_vec_i (intr_vec_i),
        .act_o      (act),
        .vec_o      (vec)
    );

    irq_seq_vaddr #(.AW(AW)) u_vaddr (
        .vec_i   (vec),
        .pmode_i (pmode_i),
        .addr_o  (tab_addr)
    );

    always_comb begin
        seq_d       = seq_q;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        case (seq_q.st)
            S_IDLE: begin
                if (bnd_i) begin
                    case (act)
                        ACT_ENTER: begin
                            seq_d.sav_fl         = fl_upd;
                            seq_d.sav_ip         = next_ip_i;
                            seq_d.fl             = fl_upd;
                            seq_d.fl[IF_BIT]     = 1'b0;
                            seq_d.ec             = ec_i;
                            seq_d.ecv            = ec_vld_i;
                            seq_d.tab            = tab_addr;
                            seq_d.st             = S_PFL;
                        end
                        ACT_RET: seq_d.st = S_OIP;
                        default: begin
                            seq_d.fl = fl_upd;
                            seq_d.ip = next_ip_i;
                        end
                    endcase
                end
            end
            S_PFL, S_PCS, S_PIP, S_PEC: begin
                mem_req_o  = 1'b1;
                mem_we_o   = 1'b1;
                mem_addr_o = seq_q.sp - WSTEP;
                seq_d.sp   = seq_q.sp - WSTEP;
                case (seq_q.st)
                    S_PFL: begin
                        mem_wdata_o = seq_q.sav_fl;
                        seq_d.st    = S_PCS;
                    end
                    S_PCS: begin
                        mem_wdata_o = seq_q.cs;
                        seq_d.st    = S_PIP;
                    end
                    S_PIP: begin
                        mem_wdata_o = seq_q.sav_ip;
                        seq_d.st    = seq_q.ecv ? S_PEC : S_ROFF;
                    end
                    default: begin
                        mem_wdata_o = seq_q.ec;
                        seq_d.st    = S_ROFF;
                    end
                endcase
            end
            S_ROFF: begin
                mem_req_o  = 1'b1;
                mem_addr_o = seq_q.tab;
                seq_d.st   = S_RSEG;
            end
            S_RSEG: begin
                mem_req_o  = 1'b1;
                mem_addr_o = seq_q.tab + WSTEP;
                seq_d.ip   = mem_rdata_i;
                seq_d.st   = S_LSEG;
            end
            S_LSEG: begin
                seq_d.cs = mem_rdata_i;
                seq_d.st = S_IDLE;
            end
            S_OIP, S_OCS, S_OFL: begin
                mem_req_o  = 1'b1;
                mem_addr_o = seq_q.sp;
                seq_d.sp   = seq_q.sp + WSTEP;
                case (seq_q.st)
                    S_OIP: seq_d.st = S_OCS;
                    S_OCS: begin
                        seq_d.ip = mem_rdata_i;
                        seq_d.st = S_OFL;
                    end
                    default: begin
                        seq_d.cs = mem_rdata_i;
                        seq_d.st = S_LFL;
                    end
                endcase
            end
            S_LFL: begin
                seq_d.fl = mem_rdata_i;
                seq_d.st = S_IDLE;
            end
            default: seq_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            seq_q        <= '0;
            seq_q.st     <= S_IDLE;
            seq_q.fl     <= DW'(FL_RST);
            seq_q.cs     <= DW'(CS_RST);
            seq_q.ip     <= DW'(IP_RST);
            seq_q.sp     <= AW'(SP_RST);
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o  = (seq_q.st != S_IDLE);
    assign flags_o = seq_q.fl;
    assign cs_o    = seq_q.cs;
    assign ip_o    = seq_q.ip;
    assign sp_o    = seq_q.sp;

    logic wr_now;
    logic idle_bnd;
    assign wr_now   = mem_req_o && mem_we_o;
    assign idle_bnd = bnd_i && !busy_o;

    AST_ENTRY_IF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.st == S_PFL) |-> !flags_o[IF_BIT]); // R4

    AST_PUSH_DESCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_now && $past(wr_now)) |-> (mem_addr_o == $past(mem_addr_o) - WSTEP)); // R2

    AST_POP_ASCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.st == S_OCS || seq_q.st == S_OFL) |-> (mem_addr_o == $past(mem_addr_o) + WSTEP)); // R6

    AST_TABLE_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.st == S_ROFF) |-> (mem_addr_o[1:0] == 2'b00)); // R5

    AST_MASKED_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (idle_bnd && intr_i && !nmi_i && !swi_i && !iret_i && (cli_i || !flags_o[IF_BIT]))
        |=> !busy_o); // R7

    AST_ENABLE_LATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (idle_bnd && sti_i && !flags_o[IF_BIT] && !nmi_i && !swi_i && !iret_i)
        |=> !busy_o); // R8

    AST_NMI_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (idle_bnd && nmi_i) |=> busy_o); // R9

    AST_QUIET_OFF_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bnd_i && !busy_o) |=> (!busy_o && $stable(ip_o) && $stable(sp_o))); // R10

endmodule

// File: tb/sim_irq_seq.sv
module sim_irq_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bnd = 0, swi = 0, iret = 0, nmi = 0, intr = 0;
    logic        sti = 0, cli = 0, ecv = 0, pm = 0;
    logic [7:0]  swi_vec = 0, intr_vec = 0;
    logic [15:0] nip = 0, ec = 0;
    logic        busy, req, we;
    logic [15:0] addr, wdata, rdata = 0;
    logic [15:0] fl, cs, ip, sp;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_seq u0 (
        .clk_i(clk), .rst_ni(rst_n), .bnd_i(bnd), .next_ip_i(nip),
        .swi_i(swi), .swi_vec_i(swi_vec), .iret_i(iret), .nmi_i(nmi),
        .intr_i(intr), .intr_vec_i(intr_vec), .sti_i(sti), .cli_i(cli),
        .ec_vld_i(ecv), .ec_i(ec), .pmode_i(pm), .busy_o(busy),
        .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr),
        .mem_wdata_o(wdata), .mem_rdata_i(rdata), .flags_o(fl),
        .cs_o(cs), .ip_o(ip), .sp_o(sp)
    );

    // Stack region 0800h..0FFFh is RAM; below 0800h the table reads as addr^5A5Ah.
    logic [15:0] stk [0:1023];
    logic [15:0] mw  [0:1023];

    always @(posedge clk) begin
        if (req) begin
            if (we) begin
                if (addr[15:11] == 5'b00001) stk[addr[10:1]] <= wdata;
            end else begin
                rdata <= (addr[15:11] == 5'b00001) ? stk[addr[10:1]] : (addr ^ 16'h5A5A);
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic [1:0]  kind;   // 0 none, 1 software interrupt, 2 return
        logic        nmi, intr, sti, cli, ecv, pm;
        logic [7:0]  vec;
        logic [15:0] ec;
        logic [15:0] nip;
    } row_t;

    localparam int NR = 15;
    localparam row_t ROWS [NR] = '{
        '{2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h20, 16'h0000, 16'h0100},
        '{2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h20, 16'h0000, 16'h0102},
        '{2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000},
        '{2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h21, 16'h0000, 16'h0104},
        '{2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000},
        '{2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h04, 16'h0000, 16'h0106},
        '{2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000},
        '{2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h30, 16'h0000, 16'h0108},
        '{2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h30, 16'h0000, 16'h010A},
        '{2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 16'h0000, 16'h010C},
        '{2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000},
        '{2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h010E},
        '{2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 16'hBEEF, 16'h0110},
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0112},
        '{2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h40, 16'h0000, 16'h0114}
    };

    logic [15:0] m_fl = 16'h0002, m_cs = 16'hF000, m_ip = 16'hFFF0, m_sp = 16'h1000;

    task automatic apply(input row_t r);
        logic [15:0] fl_u, base, sp0;
        logic [7:0]  v;
        bit          take, ret, en;
        string       tg;
        @(negedge clk);
        bnd = 1; swi = (r.kind == 2'd1); iret = (r.kind == 2'd2);
        nmi = r.nmi; intr = r.intr; sti = r.sti; cli = r.cli;
        ecv = r.ecv; pm = r.pm; swi_vec = r.vec; intr_vec = r.vec;
        ec = r.ec; nip = r.nip;
        @(negedge clk);
        {bnd, swi, iret, nmi, intr, sti, cli, ecv} = '0;
        while (busy) @(negedge clk);
        // reference model
        fl_u = m_fl;
        if (r.sti) fl_u[9] = 1'b1;
        if (r.cli) fl_u[9] = 1'b0;
        en = m_fl[9] && !r.cli;
        take = 0; ret = 0; v = 8'd0;
        if (r.kind == 2'd1) begin take = 1; v = r.vec; end
        else if (r.kind == 2'd2) ret = 1;
        else if (r.nmi) begin take = 1; v = 8'd2; end
        else if (r.intr && en) begin take = 1; v = r.vec; end
        if (r.kind == 2'd1 && r.nmi) tg = "R11";
        else if (r.nmi) tg = "R9";
        else if (r.cli) tg = "R7";
        else if (r.sti) tg = "R8";
        else if (take) tg = "R2";
        else if (ret) tg = "R6";
        else tg = "R12";
        if (take) begin
            sp0 = m_sp;
            mw[10'((sp0 - 16'd2) >> 1)] = fl_u;
            mw[10'((sp0 - 16'd4) >> 1)] = m_cs;
            mw[10'((sp0 - 16'd6) >> 1)] = r.nip;
            m_sp = sp0 - 16'd6;
            if (r.ecv) begin
                mw[10'((sp0 - 16'd8) >> 1)] = r.ec;
                m_sp = sp0 - 16'd8;
            end
            chk("R2 flags word", stk[10'((sp0 - 16'd2) >> 1)], fl_u);
            chk("R2 code segment", stk[10'((sp0 - 16'd4) >> 1)], m_cs);
            chk("R2 return pointer", stk[10'((sp0 - 16'd6) >> 1)], r.nip);
            if (r.ecv) chk("R3 error code", stk[10'((sp0 - 16'd8) >> 1)], r.ec);
            base = r.pm ? {5'd0, v, 3'd0} : {6'd0, v, 2'd0};
            m_ip = base ^ 16'h5A5A;
            m_cs = (base + 16'd2) ^ 16'h5A5A;
            m_fl = fl_u & ~16'h0200;
            chk("R5 handler ip", ip, m_ip);
            chk("R5 handler cs", cs, m_cs);
            chk("R4 flags after entry", fl, m_fl);
        end else if (ret) begin
            m_ip = mw[10'(m_sp >> 1)];
            m_cs = mw[10'((m_sp + 16'd2) >> 1)];
            m_fl = mw[10'((m_sp + 16'd4) >> 1)];
            m_sp = m_sp + 16'd6;
            chk("R6 restored ip", ip, m_ip);
            chk("R6 restored cs", cs, m_cs);
            chk("R6 restored flags", fl, m_fl);
        end else begin
            m_fl = fl_u;
            m_ip = r.nip;
            chk({tg, " next ip"}, ip, m_ip);
            chk({tg, " cs kept"}, cs, m_cs);
            chk({tg, " flags"}, fl, m_fl);
        end
        chk({tg, " stack pointer"}, sp, m_sp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ip", ip, 16'hFFF0);
        chk("R1 cs", cs, 16'hF000);
        chk("R1 flags", fl, 16'h0002);
        chk("R1 sp", sp, 16'h1000);
        chk("R1 busy", {15'd0, busy}, 16'd0);
        chk("R1 mem req", {15'd0, req}, 16'd0);

        for (int i = 0; i < NR; i++) apply(ROWS[i]);

        // R10: requests and commands held without a boundary strobe
        @(negedge clk);
        nmi = 1; intr = 1; swi = 1; iret = 1; cli = 1; nip = 16'h7777;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk("R10 busy stays low", {15'd0, busy}, 16'd0);
        end
        chk("R10 ip unchanged", ip, m_ip);
        chk("R10 sp unchanged", sp, m_sp);
        chk("R10 flags unchanged", fl, m_fl);
        {nmi, intr, swi, iret, cli} = '0;

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule